// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This controller sits above a single-shot AUX channel engine and turns one software request into a bounded series of attempts. Each attempt starts with a one-cycle launch strobe. The engine answers later with a result class, a reply code and a count of returned bytes. From that answer the controller chooses one of three actions: finish with success, finish with failure, or retry. A retry may first wait a fixed or programmed number of microseconds, counted on an external tick.

Each kind of trouble has its own budget. Short reads, defers, I2C defers, timeouts and invalid replies each have a separate counter. A timeout that arrives after a defer has been seen is charged to the defer budget. A plain I2C defer empties the defer counter. The write flag, the expected length and the defer delay are captured when a request is accepted.

Top module: `aux_retry_ctrl`

## Requirements
- R1: After reset, and whenever idle, `busy_o`, `launch_o`, `done_o`, `ok_o` and `fail_o` are all low.
- R2: `start_i` is accepted only while `busy_o` is low. Acceptance latches `wr_i`, `len_i` and `defer_us_i`, clears every counter and the defer-seen flag, and raises `launch_o` in the next cycle. A start while busy has no effect.
- R3: `launch_o` is a one-cycle pulse per attempt. There are at most 7 attempts. If a retry would be needed after the 7th attempt, the controller ends with fail.
- R4: A successful class (0) with ACK reply (0) ends in success, unless the request is a read (`wr_i` = 0) with `rx_cnt_i` < `len_i`. Such a short read increments the short-read counter, fails when that counter reaches 7, and otherwise waits 300 µs before retrying. Every wait ends with `launch_o` high in the cycle after the Nth `us_tick_i` sampled during the wait.
- R5: A native defer reply (2) or a bridged I2C defer reply (4) sets a sticky defer-seen flag and increments the defer counter. The transfer fails when that counter reaches 7; otherwise the controller waits `defer_us_i` µs before retrying. A zero delay relaunches in the cycle after the result.
- R6: A bridged I2C NACK reply (3) increments the defer counter and retries at once. It does not set the defer-seen flag.
- R7: A plain I2C defer reply (5) clears the defer counter and increments the I2C-defer counter. The transfer fails when that counter reaches 7; otherwise it retries at once.
- R8: The transfer fails at once on any of these: native NACK reply (1), disconnect reply (6), reply 7, disconnect class (3), engine-unavailable class (4), or classes 5 to 7.
- R9: An invalid-reply class (1) increments a counter. The transfer fails when it reaches 2; otherwise the controller waits 400 µs before retrying.
- R10: A timeout class (2) is handled exactly like a defer (R5) when the defer-seen flag is set. Otherwise it increments a timeout counter, fails when that counter reaches 3, and retries at once.
- R11: Any result of class 0 clears the timeout and invalid-reply counters.
- R12: `done_o` is a one-cycle pulse in the cycle after the deciding result, with exactly one of `ok_o`/`fail_o` high. `busy_o` falls in the cycle after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a new transfer |
| wr_i | input | 1 | Transfer is a write |
| len_i | input | LEN_W | Expected byte count |
| defer_us_i | input | DLY_W | Wait after a defer, in µs |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| launch_o | output | 1 | Start one engine attempt |
| res_valid_i | input | 1 | Engine result valid |
| res_class_i | input | 3 | Engine result class |
| reply_i | input | 3 | Reply code |
| rx_cnt_i | input | LEN_W | Data bytes returned |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer finished (pulse) |
| ok_o | output | 1 | Finished with success |
| fail_o | output | 1 | Finished with failure |

## Verification
Scripted engine answers are fed to the controller, and a behavioural model predicts every output on every clock.

Each mix of answers is chosen to expose a distinct decision:
- Runs of a single failure kind hit each budget exactly at its limit.
- A failure interleaved with a good class shows whether the counters are cleared.
- Timeouts after a defer, set against timeouts after a bridged NACK, separate the sticky flag from the shared defer counter.
- An alternating defer/I2C-defer run can only be stopped by the attempt cap.

Wait lengths are checked to the cycle against the tick count. A start pulse injected mid-transfer must leave the outcome unchanged.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;
  localparam int CNT_W = 4;

  localparam logic [2:0] CLS_OK        = 3'd0;
  localparam logic [2:0] CLS_INVALID   = 3'd1;
  localparam logic [2:0] CLS_TIMEOUT   = 3'd2;
  localparam logic [2:0] CLS_DISCON    = 3'd3;
  localparam logic [2:0] CLS_NO_ENGINE = 3'd4;

  localparam logic [2:0] RP_ACK          = 3'd0;
  localparam logic [2:0] RP_NACK         = 3'd1;
  localparam logic [2:0] RP_DEFER        = 3'd2;
  localparam logic [2:0] RP_BRIDGE_NACK  = 3'd3;
  localparam logic [2:0] RP_BRIDGE_DEFER = 3'd4;
  localparam logic [2:0] RP_I2C_DEFER    = 3'd5;
  localparam logic [2:0] RP_DISCON       = 3'd6;

  typedef enum logic [1:0] {ACT_OK, ACT_FAIL, ACT_RETRY} act_e;

  typedef struct packed {
    logic [CNT_W-1:0] short_n;
    logic [CNT_W-1:0] defer_n;
    logic [CNT_W-1:0] i2c_n;
    logic [CNT_W-1:0] tmo_n;
    logic [CNT_W-1:0] inv_n;
    logic             defer_seen;
  } tally_t;
endpackage

// File: rtl/aux_retry_decide.sv
module aux_retry_decide
  import aux_retry_pkg::*;
#(
  parameter int LEN_W           = 5,
  parameter int DLY_W           = 10,
  parameter int WAIT_W          = 10,
  parameter int MAX_SHORT       = 7,
  parameter int MAX_DEFER       = 7,
  parameter int MAX_I2C_DEFER   = 7,
  parameter int MAX_TIMEOUT     = 3,
  parameter int MAX_INVALID     = 2,
  parameter int SHORT_WAIT_US   = 300,
  parameter int INVALID_WAIT_US = 400
) (
  input  logic [2:0]        res_class_i,
  input  logic [2:0]        reply_i,
  input  logic [LEN_W-1:0]  rx_cnt_i,
  input  logic              wr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DLY_W-1:0]  defer_us_i,
  input  tally_t            tally_i,
  output tally_t            tally_o,
  output act_e              act_o,
  output logic [WAIT_W-1:0] wait_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // shared path for native/bridged defers and post-defer timeouts
  task automatic take_defer(inout tally_t t, output act_e a, output logic [WAIT_W-1:0] w);
    t.defer_seen = 1'b1;
    t.defer_n    = t.defer_n + ONE;
    w            = '0;
    if (t.defer_n >= CNT_W'(MAX_DEFER)) a = ACT_FAIL;
    else begin
      a = ACT_RETRY;
      w = WAIT_W'(defer_us_i);
    end
  endtask

  always_comb begin
    tally_t            t;
    act_e              a;
    logic [WAIT_W-1:0] w;
    t = tally_i;
    a = ACT_FAIL;
    w = '0;
    if (res_class_i == CLS_OK) begin
      t.tmo_n = '0;
      t.inv_n = '0;
      case (reply_i)
        RP_ACK: begin
          if (!wr_i && (rx_cnt_i < len_i)) begin
            t.short_n = t.short_n + ONE;
            if (t.short_n >= CNT_W'(MAX_SHORT)) a = ACT_FAIL;
            else begin
              a = ACT_RETRY;
              w = WAIT_W'(SHORT_WAIT_US);
            end
          end else a = ACT_OK;
        end
        RP_DEFER, RP_BRIDGE_DEFER: take_defer(t, a, w);
        RP_BRIDGE_NACK: begin
          t.defer_n = t.defer_n + ONE;
          a = (t.defer_n >= CNT_W'(MAX_DEFER)) ? ACT_FAIL : ACT_RETRY;
        end
        RP_I2C_DEFER: begin
          t.defer_n = '0;
          t.i2c_n   = t.i2c_n + ONE;
          a = (t.i2c_n >= CNT_W'(MAX_I2C_DEFER)) ? ACT_FAIL : ACT_RETRY;
        end
        default: a = ACT_FAIL;
      endcase
    end else if (res_class_i == CLS_INVALID) begin
      t.inv_n = t.inv_n + ONE;
      if (t.inv_n >= CNT_W'(MAX_INVALID)) a = ACT_FAIL;
      else begin
        a = ACT_RETRY;
        w = WAIT_W'(INVALID_WAIT_US);
      end
    end else if (res_class_i == CLS_TIMEOUT) begin
      if (tally_i.defer_seen) take_defer(t, a, w);
      else begin
        t.tmo_n = t.tmo_n + ONE;
        a = (t.tmo_n >= CNT_W'(MAX_TIMEOUT)) ? ACT_FAIL : ACT_RETRY;
      end
    end
    tally_o = t;
    act_o   = a;
    wait_o  = w;
  end
endmodule

// File: rtl/aux_retry_wait.sv
module aux_retry_wait #(
  parameter int WAIT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] load_val_i,
  input  logic              run_i,
  input  logic              tick_i,
  output logic              expire_o
);
  logic [WAIT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                left_q <= '0;
    else if (load_i)            left_q <= load_val_i;
    else if (run_i && tick_i && left_q != '0) left_q <= left_q - WAIT_W'(1);
  end

  assign expire_o = run_i && tick_i && (left_q == WAIT_W'(1));
endmodule

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl
  import aux_retry_pkg::*;
#(
  parameter int LEN_W           = 5,
  parameter int DLY_W           = 10,
  parameter int MAX_ATTEMPTS    = 7,
  parameter int MAX_SHORT       = 7,
  parameter int MAX_DEFER       = 7,
  parameter int MAX_I2C_DEFER   = 7,
  parameter int MAX_TIMEOUT     = 3,
  parameter int MAX_INVALID     = 2,
  parameter int SHORT_WAIT_US   = 300,
  parameter int INVALID_WAIT_US = 400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DLY_W-1:0] defer_us_i,
  input  logic             us_tick_i,
  output logic             launch_o,
  input  logic             res_valid_i,
  input  logic [2:0]       res_class_i,
  input  logic [2:0]       reply_i,
  input  logic [LEN_W-1:0] rx_cnt_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ok_o,
  output logic             fail_o
);
  localparam int FIX_MAX = (SHORT_WAIT_US > INVALID_WAIT_US) ? SHORT_WAIT_US : INVALID_WAIT_US;
  localparam int DLY_MAX = (1 << DLY_W) - 1;
  localparam int WAIT_W  = $clog2(((FIX_MAX > DLY_MAX) ? FIX_MAX : DLY_MAX) + 1);
  localparam int ATT_W   = $clog2(MAX_ATTEMPTS + 1);

  typedef enum logic [2:0] {S_IDLE, S_LAUNCH, S_WAIT, S_PAUSE, S_DONE} state_e;

  state_e            state_q;
  tally_t            tally_q, tally_d;
  act_e              act;
  logic [WAIT_W-1:0] wait_us;
  logic [ATT_W-1:0]  att_q;
  logic              wr_q, ok_q, expire, load;
  logic [LEN_W-1:0]  len_q;
  logic [DLY_W-1:0]  dly_q;

  aux_retry_decide #(
    .LEN_W(LEN_W), .DLY_W(DLY_W), .WAIT_W(WAIT_W),
    .MAX_SHORT(MAX_SHORT), .MAX_DEFER(MAX_DEFER), .MAX_I2C_DEFER(MAX_I2C_DEFER),
    .MAX_TIMEOUT(MAX_TIMEOUT), .MAX_INVALID(MAX_INVALID),
    .SHORT_WAIT_US(SHORT_WAIT_US), .INVALID_WAIT_US(INVALID_WAIT_US)
  ) u_decide (
    .res_class_i(res_class_i), .reply_i(reply_i), .rx_cnt_i(rx_cnt_i),
    .wr_i(wr_q), .len_i(len_q), .defer_us_i(dly_q),
    .tally_i(tally_q), .tally_o(tally_d), .act_o(act), .wait_o(wait_us)
  );

  assign load = (state_q == S_WAIT) && res_valid_i && (act == ACT_RETRY);

  aux_retry_wait #(.WAIT_W(WAIT_W)) u_wait (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .load_val_i(wait_us),
    .run_i(state_q == S_PAUSE), .tick_i(us_tick_i), .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      tally_q <= '0;
      att_q   <= '0;
      wr_q    <= 1'b0;
      len_q   <= '0;
      dly_q   <= '0;
      ok_q    <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          wr_q    <= wr_i;
          len_q   <= len_i;
          dly_q   <= defer_us_i;
          tally_q <= '0;
          att_q   <= '0;
          state_q <= S_LAUNCH;
        end
        S_LAUNCH: begin
          att_q   <= att_q + ATT_W'(1);
          state_q <= S_WAIT;
        end
        S_WAIT: if (res_valid_i) begin
          tally_q <= tally_d;
          case (act)
            ACT_OK: begin
              ok_q    <= 1'b1;
              state_q <= S_DONE;
            end
            ACT_RETRY: begin
              if (att_q >= ATT_W'(MAX_ATTEMPTS)) begin
                ok_q    <= 1'b0;
                state_q <= S_DONE;
              end else if (wait_us == '0) state_q <= S_LAUNCH;
              else                        state_q <= S_PAUSE;
            end
            default: begin
              ok_q    <= 1'b0;
              state_q <= S_DONE;
            end
          endcase
        end
        S_PAUSE: if (expire) state_q <= S_LAUNCH;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != S_IDLE);
  assign launch_o = (state_q == S_LAUNCH);
  assign done_o   = (state_q == S_DONE);
  assign ok_o     = done_o && ok_q;
  assign fail_o   = done_o && !ok_q;
endmodule

// File: rtl/aux_retry_ctrl_chk.sv
module aux_retry_ctrl_chk
  import aux_retry_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       launch_o,
  input logic       res_valid_i,
  input logic [2:0] res_class_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       ok_o,
  input logic       fail_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pend_q <= 1'b0;
    else if (launch_o)    pend_q <= 1'b1;
    else if (res_valid_i) pend_q <= 1'b0;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!launch_o && !done_o && !ok_o && !fail_o));
  // R2
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> launch_o);
  // R3
  launch_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_o |=> !launch_o);
  // R8
  hard_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && res_valid_i && (res_class_i == CLS_DISCON || res_class_i == CLS_NO_ENGINE))
      |=> (done_o && fail_o));
  // R9
  invalid_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && res_valid_i && res_class_i == CLS_INVALID) |=> !launch_o);
  // R12
  done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ok_o != fail_o));
  // R12
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

bind aux_retry_ctrl aux_retry_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .launch_o(launch_o),
  .res_valid_i(res_valid_i), .res_class_i(res_class_i), .busy_o(busy_o),
  .done_o(done_o), .ok_o(ok_o), .fail_o(fail_o)
);

// File: tb/sim_aux_retry_ctrl.sv
module sim_aux_retry_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, wr_i = 1'b0, us_tick_i = 1'b0;
  logic [4:0] len_i = '0, rx_cnt_i = '0;
  logic [9:0] defer_i = '0;
  logic res_valid_i = 1'b0;
  logic [2:0] res_class_i = '0, reply_i = '0;
  logic launch_o, busy_o, done_o, ok_o, fail_o;

  always #2 clk = ~clk;

  aux_retry_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .wr_i(wr_i), .len_i(len_i),
    .defer_us_i(defer_i), .us_tick_i(us_tick_i), .launch_o(launch_o),
    .res_valid_i(res_valid_i), .res_class_i(res_class_i), .reply_i(reply_i),
    .rx_cnt_i(rx_cnt_i), .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o), .fail_o(fail_o)
  );

  typedef struct { int cls; int rep; int cnt; } resp_t;
  resp_t rq[$];
  int total = 0, fails = 0, n_launch = 0, lat = 0, cyc = 0;
  bit ended = 0;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    ended = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // engine stub and tick source
  always @(negedge clk) begin
    res_valid_i = 1'b0;
    if (rst_n) us_tick_i = ~us_tick_i;
    if (launch_o) begin
      n_launch++;
      lat = 3;
    end else if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        resp_t r;
        if (rq.size() > 0) r = rq.pop_front();
        else r = '{cls: 7, rep: 0, cnt: 0};
        res_class_i = 3'(r.cls);
        reply_i     = 3'(r.rep);
        rx_cnt_i    = 5'(r.cnt);
        res_valid_i = 1'b1;
      end
    end
  end

  // reference model: phase 0 idle, 1 launch, 2 await, 3 pause, 4 done
  int m_ph = 0, m_att = 0, m_left = 0, m_len = 0, m_dly = 0;
  int m_short = 0, m_def = 0, m_i2c = 0, m_tmo = 0, m_inv = 0;
  bit m_wr = 0, m_seen = 0, m_ok = 0;

  function automatic void m_defer(output int act, output int wt);
    m_seen = 1; m_def++;
    wt = 0;
    if (m_def >= 7) act = 1; else begin act = 2; wt = m_dly; end
  endfunction

  // act: 0 ok, 1 fail, 2 retry
  function automatic void m_decide(input int cls, input int rep, input int rxc,
                                   output int act, output int wt);
    act = 1; wt = 0;
    if (cls == 0) begin
      m_tmo = 0; m_inv = 0;
      if (rep == 0) begin
        if (!m_wr && rxc < m_len) begin
          m_short++;
          if (m_short >= 7) act = 1; else begin act = 2; wt = 300; end
        end else act = 0;
      end else if (rep == 2 || rep == 4) m_defer(act, wt);
      else if (rep == 3) begin m_def++; act = (m_def >= 7) ? 1 : 2; end
      else if (rep == 5) begin m_def = 0; m_i2c++; act = (m_i2c >= 7) ? 1 : 2; end
    end else if (cls == 1) begin
      m_inv++;
      if (m_inv >= 2) act = 1; else begin act = 2; wt = 400; end
    end else if (cls == 2) begin
      if (m_seen) m_defer(act, wt);
      else begin m_tmo++; act = (m_tmo >= 3) ? 1 : 2; end
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_ph = 0;
    else begin
      case (m_ph)
        0: if (start_i) begin
          m_wr = wr_i; m_len = int'(len_i); m_dly = int'(defer_i);
          m_short = 0; m_def = 0; m_i2c = 0; m_tmo = 0; m_inv = 0; m_seen = 0;
          m_att = 0; m_ph = 1;
        end
        1: begin m_att++; m_ph = 2; end
        2: if (res_valid_i) begin
          int act, wt;
          m_decide(int'(res_class_i), int'(reply_i), int'(rx_cnt_i), act, wt);
          if (act == 0) begin m_ok = 1; m_ph = 4; end
          else if (act == 1 || m_att >= 7) begin m_ok = 0; m_ph = 4; end
          else if (wt == 0) m_ph = 1;
          else begin m_left = wt; m_ph = 3; end
        end
        3: if (us_tick_i) begin
          m_left--;
          if (m_left == 0) m_ph = 1;
        end
        default: m_ph = 0;
      endcase
    end
  end

  // per-cycle comparison (R12 timing, R3 pulses, R1 idle)
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk("R12", "busy_o", int'(busy_o), int'(m_ph != 0));
      chk("R3", "launch_o", int'(launch_o), int'(m_ph == 1));
      chk("R12", "done_o", int'(done_o), int'(m_ph == 4));
      chk("R12", "ok_o", int'(ok_o), int'(m_ph == 4 && m_ok));
      chk("R12", "fail_o", int'(fail_o), int'(m_ph == 4 && !m_ok));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !ended) begin
      fails++; total++;
      $display("FAIL R12 watchdog: actual=hung expected=done");
      summary();
    end
  end

  function automatic void push(int cls, int rep, int cnt);
    rq.push_back('{cls: cls, rep: rep, cnt: cnt});
  endfunction

  task automatic run(string req, bit wr, int len, int dly, int exp_n, bit exp_ok, bit poke);
    int guard = 0;
    n_launch = 0;
    @(negedge clk);
    start_i = 1; wr_i = wr; len_i = 5'(len); defer_i = 10'(dly);
    @(negedge clk);
    start_i = 0;
    while (!done_o && guard < 60000) begin
      if (poke && guard == 20) begin start_i = 1; wr_i = ~wr; len_i = 5'd31; defer_i = '0; end
      else start_i = 0;
      @(negedge clk);
      guard++;
    end
    start_i = 0;
    chk(req, "outcome ok", int'(ok_o), int'(exp_ok));
    chk(req, "attempts", n_launch, exp_n);
    rq.delete();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1", "reset busy", int'(busy_o), 0);
    chk("R1", "reset done", int'(done_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "idle launch", int'(launch_o), 0);

    push(0, 0, 0);                         run("R4", 1, 4, 5, 1, 1, 0); // write ACK
    push(0, 0, 2); push(0, 0, 4);          run("R4", 0, 4, 5, 2, 1, 0); // short then full
    for (int i = 0; i < 7; i++) push(0, 0, 1);
                                           run("R4", 0, 4, 5, 7, 0, 0); // short-read budget
    push(0, 1, 0);                         run("R8", 0, 2, 5, 1, 0, 0); // native NACK
    push(0, 6, 0);                         run("R8", 0, 2, 5, 1, 0, 0); // disconnect reply
    push(3, 0, 0);                         run("R8", 0, 2, 5, 1, 0, 0); // disconnect class
    push(4, 0, 0);                         run("R8", 0, 2, 5, 1, 0, 0); // no engine
    push(6, 0, 0);                         run("R8", 0, 2, 5, 1, 0, 0); // unknown class
    push(1, 0, 0); push(1, 0, 0);          run("R9", 0, 2, 5, 2, 0, 0);
    push(1, 0, 0); push(0, 0, 2);          run("R2", 0, 2, 5, 2, 1, 1); // busy start ignored
    push(2, 0, 0); push(2, 0, 0); push(2, 0, 0); run("R10", 0, 2, 5, 3, 0, 0);
    push(2, 0, 0); push(2, 0, 0); push(0, 0, 0); push(2, 0, 0); push(2, 0, 0); push(0, 0, 4);
                                           run("R11", 0, 4, 5, 6, 1, 0); // timeout counter cleared
    push(1, 0, 0); push(0, 0, 0); push(1, 0, 0); push(0, 0, 3);
                                           run("R11", 0, 3, 5, 4, 1, 0); // invalid counter cleared
    push(0, 2, 0); push(2, 0, 0); push(2, 0, 0); push(2, 0, 0); push(0, 0, 2);
                                           run("R10", 0, 2, 5, 5, 1, 0); // timeouts after defer
    push(0, 4, 0); push(2, 0, 0); push(2, 0, 0); push(2, 0, 0); push(0, 0, 2);
                                           run("R5", 0, 2, 5, 5, 1, 0); // bridged defer sets flag
    push(0, 2, 0); push(0, 0, 2);          run("R5", 0, 2, 0, 2, 1, 0); // zero defer delay
    for (int i = 0; i < 7; i++) push(0, 2, 0);
                                           run("R5", 0, 2, 3, 7, 0, 0);
    push(0, 3, 0); push(0, 3, 0); push(0, 0, 2); run("R6", 0, 2, 5, 3, 1, 0);
    push(0, 3, 0); push(2, 0, 0); push(2, 0, 0); push(2, 0, 0);
                                           run("R6", 0, 2, 5, 4, 0, 0); // NACK sets no flag
    push(0, 2, 0); push(0, 2, 0); push(0, 5, 0); push(0, 0, 2);
                                           run("R7", 0, 2, 5, 4, 1, 0);
    for (int i = 0; i < 7; i++) push(0, 5, 0);
                                           run("R7", 0, 2, 5, 7, 0, 0);
    for (int i = 0; i < 4; i++) begin push(0, 2, 0); push(0, 5, 0); end
    push(0, 0, 2);                         run("R3", 0, 2, 1, 7, 0, 0); // attempt cap
    repeat (20) @(negedge clk);
    chk("R1", "idle after runs", int'(busy_o), 0);
    summary();
  end
endmodule